// File: doc/BRIEF.md
# Bus Cycle Request Status Tracker

This block is the control and status register slice that sits between a local processor and an outbound bus master engine. The processor starts outbound cycles of three kinds (I/O, configuration, block DMA) by pulsing one request strobe per kind. The block tracks each kind with a busy flag and a done flag. It refuses any request that collides with work already under way and records that refusal in an error flag.

I/O and configuration requests form one class that shares one collision check and one error flag. DMA forms a class of its own. The bus engine reports completions and two kinds of abort (target abort and master abort). Each abort sets a flag in the main status word and, on the same edge, a second flag in a separate mirror register. The two copies clear independently. Every event flag can be enabled onto one level-sensitive interrupt line. Software reads and clears the flags through a small register port.

Top module: `bcr_status_tracker`

## Requirements
- R1: After synchronous reset, every busy, done, error and abort flag is zero, the enable register is zero, `irq` is low and `reg_rdata` is zero.
- R2: A request that is accepted sets that kind's busy flag on the next clock edge. A completion pulse for a busy kind clears its busy flag and sets its done flag. A completion pulse for a kind that is not busy has no effect. In the STATUS word (address 0), busy flags sit in bits 2:0 and done flags in bits 6:4, in the order I/O, configuration, DMA.
- R3: Writing a one to a done bit in STATUS clears it. Writing zero leaves it unchanged. Busy bits cannot be written.
- R4: An I/O or configuration request made while an I/O or a configuration cycle is busy is ignored, and STATUS bit 8 is set. If I/O and configuration requests arrive together while idle, the I/O request is accepted, the configuration request is rejected, and bit 8 is set.
- R5: A DMA request made while DMA is busy is ignored and sets STATUS bit 9. DMA acceptance does not depend on the I/O and configuration class.
- R6: STATUS bits 8 and 9 are cleared by writing a one to them.
- R7: A target-abort pulse sets STATUS bit 10 and MIRROR bit 0 (address 2) on the same edge. A master-abort pulse sets STATUS bit 11 and MIRROR bit 1. Each copy is cleared only by writing a one to its own bit.
- R8: If a set event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R9: The enable register (address 1) resets to zero and is read back in bits 6:0. Its bits enable, in order: I/O done, configuration done, DMA done, bit-8 error, bit-9 error, target abort, master abort.
- R10: `irq` is registered. It equals the OR over all seven events of (flag AND enable) one cycle after that state, and it stays high until the flags are cleared or disabled.
- R11: `reg_rdata` shows the register selected by `reg_addr` one cycle later. Unused bits read zero, and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_io | input | 1 | I/O cycle request strobe |
| req_cfg | input | 1 | Configuration cycle request strobe |
| req_dma | input | 1 | DMA transfer request strobe |
| cmpl_io | input | 1 | I/O cycle completion pulse |
| cmpl_cfg | input | 1 | Configuration cycle completion pulse |
| cmpl_dma | input | 1 | DMA completion pulse |
| abort_tgt | input | 1 | Target abort seen on a self-initiated cycle |
| abort_mst | input | 1 | Master abort of a self-initiated cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register select: 0 STATUS, 1 enable, 2 MIRROR |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that every strobe and pulse is a clean synchronous input sampled at the clock edge. They also assume the bus engine reports a completion only for a kind it was asked to run. The properties themselves do not depend on that assumption, because a stray completion is specified to do nothing. The bench changes all inputs only on the falling edge and holds each strobe for exactly one cycle. It sends completions both to busy and to idle kinds, so that the ignore path is exercised without the assertions relying on it.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int KINDS    = 3;
  localparam int K_IO     = 0;
  localparam int K_CFG    = 1;
  localparam int K_DMA    = 2;
  localparam int BUSY_LSB = 0;
  localparam int DONE_LSB = 4;
  localparam int ERR_CTL  = 8;
  localparam int ERR_DMA  = 9;
  localparam int TABT_BIT = 10;
  localparam int MABT_BIT = 11;
  localparam int STAT_W   = 12;
  localparam int EVT_W    = 7;
  localparam int NFLAG    = 6;
  // flag slot indices
  localparam int F_ECTL = 0;
  localparam int F_EDMA = 1;
  localparam int F_TABT = 2;
  localparam int F_MABT = 3;
  localparam int F_MTGT = 4;
  localparam int F_MMST = 5;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_IRQEN  = 2'd1,
    SEL_MIRROR = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/bcr_w1c_bit.sv
module bcr_w1c_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/bcr_kind_slot.sv
module bcr_kind_slot (
  input  logic clk,
  input  logic rst,
  input  logic accept_i,
  input  logic cmpl_i,
  input  logic done_clr_i,
  output logic busy_o,
  output logic done_o
);
  logic fin;
  assign fin = cmpl_i & busy_o;

  always_ff @(posedge clk) begin
    if (rst)           busy_o <= 1'b0;
    else if (accept_i) busy_o <= 1'b1;
    else if (fin)      busy_o <= 1'b0;
  end

  bcr_w1c_bit u_done (
    .clk   (clk),
    .rst   (rst),
    .set_i (fin),
    .clr_i (done_clr_i),
    .q_o   (done_o)
  );
endmodule

// File: rtl/bcr_status_tracker.sv
module bcr_status_tracker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_io,
  input  logic              req_cfg,
  input  logic              req_dma,
  input  logic              cmpl_io,
  input  logic              cmpl_cfg,
  input  logic              cmpl_dma,
  input  logic              abort_tgt,
  input  logic              abort_mst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  import bcr_pkg::*;

  logic [KINDS-1:0] busy_q, done_q, accept, cmpl_v, done_clr;
  logic [NFLAG-1:0] fl_set, fl_clr, fl_q;
  logic [EVT_W-1:0] irq_en_q, evt;
  logic             ctl_busy, ectl_set, edma_set;
  logic             wr_stat, wr_en, wr_mir;
  logic [DATA_W-1:0] stat_w, mir_w, en_w;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata;

  // register decode
  assign wr_stat = reg_wr && (reg_addr == ADDR_W'(SEL_STATUS));
  assign wr_en   = reg_wr && (reg_addr == ADDR_W'(SEL_IRQEN));
  assign wr_mir  = reg_wr && (reg_addr == ADDR_W'(SEL_MIRROR));

  // collision and acceptance
  assign ctl_busy = busy_q[K_IO] | busy_q[K_CFG];
  assign accept[K_IO]  = req_io & ~ctl_busy;
  assign accept[K_CFG] = req_cfg & ~ctl_busy & ~req_io;
  assign accept[K_DMA] = req_dma & ~busy_q[K_DMA];
  assign ectl_set = (ctl_busy & (req_io | req_cfg)) | (req_io & req_cfg);
  assign edma_set = req_dma & busy_q[K_DMA];
  assign cmpl_v   = {cmpl_dma, cmpl_cfg, cmpl_io};

  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    assign done_clr[k] = wr_stat & reg_wdata[DONE_LSB + k];
    bcr_kind_slot u_slot (
      .clk        (clk),
      .rst        (rst),
      .accept_i   (accept[k]),
      .cmpl_i     (cmpl_v[k]),
      .done_clr_i (done_clr[k]),
      .busy_o     (busy_q[k]),
      .done_o     (done_q[k])
    );
  end

  // error and abort flags, with independent mirror copies
  assign fl_set[F_ECTL] = ectl_set;
  assign fl_set[F_EDMA] = edma_set;
  assign fl_set[F_TABT] = abort_tgt;
  assign fl_set[F_MABT] = abort_mst;
  assign fl_set[F_MTGT] = abort_tgt;
  assign fl_set[F_MMST] = abort_mst;
  assign fl_clr[F_ECTL] = wr_stat & reg_wdata[ERR_CTL];
  assign fl_clr[F_EDMA] = wr_stat & reg_wdata[ERR_DMA];
  assign fl_clr[F_TABT] = wr_stat & reg_wdata[TABT_BIT];
  assign fl_clr[F_MABT] = wr_stat & reg_wdata[MABT_BIT];
  assign fl_clr[F_MTGT] = wr_mir & reg_wdata[0];
  assign fl_clr[F_MMST] = wr_mir & reg_wdata[1];

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    bcr_w1c_bit u_flag (
      .clk   (clk),
      .rst   (rst),
      .set_i (fl_set[f]),
      .clr_i (fl_clr[f]),
      .q_o   (fl_q[f])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)        irq_en_q <= '0;
    else if (wr_en) irq_en_q <= reg_wdata[EVT_W-1:0];
  end

  // interrupt
  assign evt = {fl_q[F_MABT], fl_q[F_TABT], fl_q[F_EDMA], fl_q[F_ECTL], done_q};

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(evt & irq_en_q);
  end

  // read words
  always_comb begin
    stat_w = '0;
    stat_w[BUSY_LSB +: KINDS] = busy_q;
    stat_w[DONE_LSB +: KINDS] = done_q;
    stat_w[ERR_CTL]  = fl_q[F_ECTL];
    stat_w[ERR_DMA]  = fl_q[F_EDMA];
    stat_w[TABT_BIT] = fl_q[F_TABT];
    stat_w[MABT_BIT] = fl_q[F_MABT];
    mir_w    = '0;
    mir_w[0] = fl_q[F_MTGT];
    mir_w[1] = fl_q[F_MMST];
    en_w     = '0;
    en_w[EVT_W-1:0] = irq_en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_addr == ADDR_W'(SEL_STATUS)) reg_rdata <= stat_w;
    else if (reg_addr == ADDR_W'(SEL_IRQEN))  reg_rdata <= en_w;
    else if (reg_addr == ADDR_W'(SEL_MIRROR)) reg_rdata <= mir_w;
    else reg_rdata <= '0;
  end
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_io,
  input logic       req_cfg,
  input logic       req_dma,
  input logic       cmpl_io,
  input logic       cmpl_cfg,
  input logic       cmpl_dma,
  input logic       abort_tgt,
  input logic       abort_mst,
  input logic       irq,
  input logic [2:0] busy,
  input logic [5:0] flags,
  input logic [6:0] en
);
  logic ctl_busy;
  assign ctl_busy = busy[0] | busy[1];

  assert_io_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (!ctl_busy && req_io) |=> busy[0]);
  assert_dma_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy[2] && req_dma) |=> busy[2]);
  assert_cmpl_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (busy[2] && cmpl_dma) |=> !busy[2]);
  assert_ctl_collide_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl_busy && (req_io || req_cfg)) |=> flags[0]);
  assert_ctl_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl_busy && !cmpl_io && !cmpl_cfg) |=> $stable(busy[1:0]));
  assert_ctl_single_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(busy[1:0]));
  assert_dma_collide_R5: assert property (@(posedge clk) disable iff (rst)
    (busy[2] && req_dma) |=> flags[1]);
  assert_tabt_both_R7: assert property (@(posedge clk) disable iff (rst)
    abort_tgt |=> (flags[2] && flags[4]));
  assert_mabt_both_R7: assert property (@(posedge clk) disable iff (rst)
    abort_mst |=> (flags[3] && flags[5]));
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !irq);
endmodule

bind bcr_status_tracker bcr_checker u_bcr_checker (
  .clk       (clk),
  .rst       (rst),
  .req_io    (req_io),
  .req_cfg   (req_cfg),
  .req_dma   (req_dma),
  .cmpl_io   (cmpl_io),
  .cmpl_cfg  (cmpl_cfg),
  .cmpl_dma  (cmpl_dma),
  .abort_tgt (abort_tgt),
  .abort_mst (abort_mst),
  .irq       (irq),
  .busy      (busy_q),
  .flags     (fl_q),
  .en        (irq_en_q)
);

// File: tb/test_bcr_status_tracker.sv
module test_bcr_status_tracker;
  localparam int DW = 32;
  localparam int AW = 2;
  localparam logic [AW-1:0] A_ST = 2'd0, A_EN = 2'd1, A_MIR = 2'd2, A_NONE = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_io = 0, req_cfg = 0, req_dma = 0;
  logic cmpl_io = 0, cmpl_cfg = 0, cmpl_dma = 0;
  logic abort_tgt = 0, abort_mst = 0;
  logic reg_wr = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  bcr_status_tracker #(.DATA_W(DW), .ADDR_W(AW)) i_bcr_status_tracker (
    .clk(clk), .rst(rst),
    .req_io(req_io), .req_cfg(req_cfg), .req_dma(req_dma),
    .cmpl_io(cmpl_io), .cmpl_cfg(cmpl_cfg), .cmpl_dma(cmpl_dma),
    .abort_tgt(abort_tgt), .abort_mst(abort_mst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one cycle: whatever strobes are set are seen by one rising edge
  task automatic tick();
    @(negedge clk);
    {req_io, req_cfg, req_dma, cmpl_io, cmpl_cfg, cmpl_dma, abort_tgt, abort_mst, reg_wr} = '0;
  endtask

  // bits: 0 req_io 1 req_cfg 2 req_dma 3 cmpl_io 4 cmpl_cfg 5 cmpl_dma 6 abort_tgt 7 abort_mst
  task automatic pulse(input logic [7:0] v);
    {abort_mst, abort_tgt, cmpl_dma, cmpl_cfg, cmpl_io, req_dma, req_cfg, req_io} = v;
    tick();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    check("R1 rdata after reset", reg_rdata, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(A_ST, d);  check("R1 status after reset", d, 32'h0);
    rd(A_EN, d);  check("R1 enables after reset", d, 32'h0);
    rd(A_MIR, d); check("R1 mirror after reset", d, 32'h0);
  endtask

  task automatic t_req_cmpl();
    logic [DW-1:0] d;
    pulse(8'h01);
    rd(A_ST, d); check("R2 io busy", d, 32'h001);
    pulse(8'h08);
    rd(A_ST, d); check("R2 io done, not busy", d, 32'h010);
    pulse(8'h10); // completion for idle cfg
    rd(A_ST, d); check("R2 idle completion ignored", d, 32'h010);
    wr(A_ST, 32'h0000_0007); // busy bits not writable, done untouched
    rd(A_ST, d); check("R3 zero write keeps done", d, 32'h010);
    wr(A_ST, 32'h0000_0010);
    rd(A_ST, d); check("R3 done cleared", d, 32'h000);
  endtask

  task automatic t_ctl_collide();
    logic [DW-1:0] d;
    pulse(8'h02);         // cfg accepted
    pulse(8'h01);         // io rejected
    rd(A_ST, d); check("R4 io rejected during cfg", d, 32'h102);
    wr(A_ST, 32'h100);
    rd(A_ST, d); check("R6 bit8 cleared", d, 32'h002);
    pulse(8'h10);         // cfg completes
    wr(A_ST, 32'h020);
    pulse(8'h03);         // io and cfg together while idle
    rd(A_ST, d); check("R4 simultaneous io wins", d, 32'h101);
    pulse(8'h08);
    wr(A_ST, 32'h110);
    rd(A_ST, d); check("R4 cleanup", d, 32'h000);
  endtask

  task automatic t_dma();
    logic [DW-1:0] d;
    pulse(8'h01);
    pulse(8'h04);
    rd(A_ST, d); check("R5 dma independent of io", d, 32'h005);
    pulse(8'h04);
    rd(A_ST, d); check("R5 dma collision bit9", d, 32'h205);
    wr(A_ST, 32'h200);
    rd(A_ST, d); check("R6 bit9 cleared", d, 32'h005);
    pulse(8'h28);
    wr(A_ST, 32'h050);
    rd(A_ST, d); check("R5 cleanup", d, 32'h000);
  endtask

  task automatic t_abort();
    logic [DW-1:0] d;
    pulse(8'h40);
    rd(A_ST, d);  check("R7 tgt abort status", d, 32'h400);
    rd(A_MIR, d); check("R7 tgt abort mirror", d, 32'h1);
    wr(A_ST, 32'h400);
    rd(A_ST, d);  check("R7 status cleared alone", d, 32'h000);
    rd(A_MIR, d); check("R7 mirror kept", d, 32'h1);
    wr(A_MIR, 32'h1);
    pulse(8'h80);
    wr(A_MIR, 32'h2);
    rd(A_MIR, d); check("R7 mst mirror cleared", d, 32'h0);
    rd(A_ST, d);  check("R7 mst status kept", d, 32'h800);
    wr(A_ST, 32'h800);
  endtask

  task automatic t_set_wins();
    logic [DW-1:0] d;
    abort_tgt = 1'b1;
    wr(A_ST, 32'h400);
    rd(A_ST, d); check("R8 set beats clear", d, 32'h400);
    wr(A_ST, 32'h400);
    wr(A_MIR, 32'h1);
    rd(A_MIR, d); check("R8 cleanup", d, 32'h0);
  endtask

  task automatic t_irq();
    logic [DW-1:0] d;
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, d); check("R9 enable readback", d, 32'h7F);
    check("R10 no flags no irq", {31'b0, irq}, 32'h0);
    rd(A_NONE, d); check("R11 unmapped reads zero", d, 32'h0);
    wr(A_EN, 32'h04);     // DMA done only
    pulse(8'h04);
    pulse(8'h20);
    @(negedge clk);
    check("R10 irq on dma done", {31'b0, irq}, 32'h1);
    wr(A_EN, 32'h01);
    @(negedge clk);
    check("R10 irq masked", {31'b0, irq}, 32'h0);
    wr(A_EN, 32'h04);
    repeat (3) @(negedge clk);
    check("R10 irq level holds", {31'b0, irq}, 32'h1);
    wr(A_ST, 32'h040);
    @(negedge clk);
    check("R10 irq drops on clear", {31'b0, irq}, 32'h0);
    wr(A_EN, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_req_cmpl();
    t_ctl_collide();
    t_dma();
    t_abort();
    t_set_wins();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule